// File: doc/BRIEF.md
# Capture/compare PWM unit

This block is a 16-bit timer with a clock prescaler. Four compare channels turn the timer value into PWM waveforms, and two capture channels record the timer value when an external input changes. The counter runs in one of three ways:

- edge-aligned PWM, where it always counts down from the reload value;
- center-aligned PWM, where it ramps up and then down;
- plain timer, where the direction bit sets the direction.

In edge-aligned PWM the channels can be paired (A with B, C with D) so that each channel of a pair is enabled only on every other counter cycle. This suits the two halves of a bridge driver.

Software programs the unit through a write-only register port. The port sets the reload value, four buffered compare values, the prescaler divisor, a control word, an interrupt enable mask and a flag-clear strobe. Seven event flags (overflow, two captures, four compare matches) are visible at the ports. Their enabled OR drives a single interrupt line.

Top module: `ccpwm_top`

## Requirements
- R1: In edge-aligned PWM mode (control bit 1 set, bit 2 clear) each prescaler tick moves the counter down by one. From 0 it reloads the reload register (address 0) and raises overflow flag bit 0, so one counter cycle lasts reload+1 ticks.
- R2: The prescaler field (address 5, 10 bits, value P) gives one counter tick every P+1 clocks while the run bit (control bit 0) is set. A tick comes every clock for P=0 and every 1024 clocks for P=1023.
- R3: Compare channel i (addresses 1..4 for A..D) is active while the counter is below its active compare value. A compare of 0 is never active, and a compare above the reload value is always active.
- R4: Control bits 5..8 invert outputs A..D respectively; pwm_o[i] is the active state XOR its polarity bit.
- R5: In edge-aligned PWM mode the direction bit (control bit 3) is ignored and the counter still counts down.
- R6: In center-aligned PWM mode (control bits 1 and 2 set, reload at least 1) the counter visits 0, 1 .. reload, reload-1 .. 1 and repeats. Overflow is flagged at 0, so one counter cycle lasts 2*reload ticks.
- R7: With control bit 4 set in edge-aligned PWM mode, channels A and C are enabled on one counter cycle and B and D on the next, alternating. A disabled channel shows its inactive level.
- R8: A written compare value reaches its channel only at the next overflow point. Until then the channel keeps using its previous value.
- R9: With control bit 1 clear each output stays at its polarity level. The counter then counts up from 0 to the reload value when bit 3 is set, and down otherwise.
- R10: Each capture input passes through a two-flop synchronizer. Control bits 9/10 select, for inputs A/B, the rising edge (1) or the falling edge (0). On the selected edge the counter value is stored in cap_val_o[j] and flag bit 1+j is set; the other edge does nothing.
- R11: Flag bits 3..6 are set when a tick moves the counter onto the active compare value of channel A..D. Flags stay set until 1 is written to the same bit at address 8. A set in the same cycle wins over the clear.
- R12: irq_o is high exactly when some flag is set whose bit in the enable register (address 7) is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | 16 | Register write data |
| cap_i | input | 2 | Asynchronous capture inputs A, B |
| pwm_o | output | 4 | PWM outputs A..D |
| cap_val_o | output | 32 | Captured counter values, input B in the upper half |
| flags_o | output | 7 | Event flags: overflow, capture A/B, compare A..D |
| irq_o | output | 1 | Shared interrupt request |

## Verification
A counter that steps wrongly, or that misses its reload, changes the duty of all four outputs and the spacing of overflow flags within one counter cycle. The bench therefore measures high-time over whole even numbers of cycles, and the gap between overflows. A shadow compare that loads at the wrong moment shows on the very next partial cycle: the high-time measured before the following reload differs from the old compare value. A synchronizer or edge selector that misbehaves shows up within three clocks of the input change, either as a wrong captured value or as a flag on the ignored edge.

// File: rtl/ccpwm_pkg.sv
package ccpwm_pkg;
    localparam int CNT_W  = 16;
    localparam int PSC_W  = 10;
    localparam int NCMP   = 4;
    localparam int NCAP   = 2;
    localparam int ADDR_W = 4;

    // control word bit positions
    localparam int C_RUN = 0;
    localparam int C_PWM = 1;
    localparam int C_SYM = 2;
    localparam int C_UP  = 3;
    localparam int C_ALT = 4;
    localparam int C_POL = 5;
endpackage

// File: rtl/ccpwm_prescale.sv
module ccpwm_prescale #(
    parameter int PSC_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [PSC_W-1:0] div_i,
    output logic             tick_o
);
    logic [PSC_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q >= div_i);
        cnt_d  = cnt_q;
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + PSC_W'(1);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    // R2: every tick restarts the divider from zero
    p_tick_restart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/ccpwm_timer.sv
module ccpwm_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             pwm_i,
    input  logic             sym_i,
    input  logic             up_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] nxt_o,
    output logic             ovf_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             up;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        ovf_o = 1'b0;
        if (tick_i) begin
            if (pwm_i && sym_i) begin
                if (st_q.up) begin
                    if (st_q.cnt >= reload_i) begin
                        st_d.up  = 1'b0;
                        st_d.cnt = (st_q.cnt == '0) ? '0 : st_q.cnt - CNT_W'(1);
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end else if (st_q.cnt == '0) begin
                    st_d.up  = 1'b1;
                    st_d.cnt = (reload_i == '0) ? '0 : CNT_W'(1);
                    ovf_o    = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end else if (pwm_i || !up_i) begin
                st_d.up = 1'b0;
                if (st_q.cnt == '0) begin
                    st_d.cnt = reload_i;
                    ovf_o    = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end else begin
                st_d.up = 1'b1;
                if (st_q.cnt >= reload_i) begin
                    st_d.cnt = '0;
                    ovf_o    = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
        end
        cnt_o = st_q.cnt;
        nxt_o = st_d.cnt;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R5: edge-aligned PWM steps down whatever the direction bit says
    p_asym_down_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && pwm_i && !sym_i && st_q.cnt != '0) |=>
            (st_q.cnt == $past(st_q.cnt) - CNT_W'(1)));

    // R6: center-aligned ramp keeps rising until it reaches the reload value
    p_sym_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && pwm_i && sym_i && st_q.up && st_q.cnt < reload_i) |=>
            (st_q.up && st_q.cnt == $past(st_q.cnt) + CNT_W'(1)));
endmodule

// File: rtl/ccpwm_capture.sv
module ccpwm_capture #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pin_i,
    input  logic             rise_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] val_o,
    output logic             evt_o
);
    typedef struct packed {
        logic [2:0]       sync;
        logic [CNT_W-1:0] val;
    } cap_t;

    cap_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[1:0], pin_i};
        evt_o     = rise_i ? (st_q.sync[1] && !st_q.sync[2])
                           : (!st_q.sync[1] && st_q.sync[2]);
        if (evt_o) st_d.val = cnt_i;
        val_o     = st_q.val;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R10: the stored value only moves on a selected edge
    p_cap_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !evt_o |=> $stable(val_o));
endmodule

// File: rtl/ccpwm_top.sv
module ccpwm_top
    import ccpwm_pkg::*;
#(
    parameter int CNT_W_P  = CNT_W,
    parameter int PSC_W_P  = PSC_W,
    parameter int NCMP_P   = NCMP,
    parameter int NCAP_P   = NCAP,
    parameter int ADDR_W_P = ADDR_W
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            wr_en_i,
    input  logic [ADDR_W_P-1:0]             wr_addr_i,
    input  logic [CNT_W_P-1:0]              wr_data_i,
    input  logic [NCAP_P-1:0]               cap_i,
    output logic [NCMP_P-1:0]               pwm_o,
    output logic [NCAP_P-1:0][CNT_W_P-1:0]  cap_val_o,
    output logic [NCAP_P+NCMP_P:0]          flags_o,
    output logic                            irq_o
);
    localparam int NFLAG  = 1 + NCAP_P + NCMP_P;
    localparam int C_EDGE = C_POL + NCMP_P;
    localparam int CTRL_W = C_EDGE + NCAP_P;
    localparam int F_CAP  = 1;
    localparam int F_OC   = 1 + NCAP_P;
    localparam int A_CMP0 = 1;
    localparam int A_PSC  = A_CMP0 + NCMP_P;
    localparam int A_CTRL = A_PSC + 1;
    localparam int A_IEN  = A_PSC + 2;
    localparam int A_FCLR = A_PSC + 3;

    typedef struct packed {
        logic [CNT_W_P-1:0]               reload;
        logic [NCMP_P-1:0][CNT_W_P-1:0]   cmp_sh;
        logic [NCMP_P-1:0][CNT_W_P-1:0]   cmp_act;
        logic [PSC_W_P-1:0]               psc;
        logic [CTRL_W-1:0]                ctrl;
        logic [NFLAG-1:0]                 ien;
        logic [NFLAG-1:0]                 flags;
        logic                             gate;
    } regs_t;

    regs_t st_d, st_q;

    logic                 tick_w, ovf_w;
    logic [CNT_W_P-1:0]   cnt_w, nxt_w;
    logic [NCAP_P-1:0]    cap_evt;
    logic [NFLAG-1:0]     set_vec, clr_mask, keep_w;
    logic [NCMP_P-1:0]    act;
    logic                 alt_on;

    ccpwm_prescale #(.PSC_W(PSC_W_P)) u_psc (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .run_i (st_q.ctrl[C_RUN]),
        .div_i (st_q.psc),
        .tick_o(tick_w)
    );

    ccpwm_timer #(.CNT_W(CNT_W_P)) u_tmr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick_w),
        .pwm_i   (st_q.ctrl[C_PWM]),
        .sym_i   (st_q.ctrl[C_SYM]),
        .up_i    (st_q.ctrl[C_UP]),
        .reload_i(st_q.reload),
        .cnt_o   (cnt_w),
        .nxt_o   (nxt_w),
        .ovf_o   (ovf_w)
    );

    for (genvar j = 0; j < NCAP_P; j++) begin : g_cap
        ccpwm_capture #(.CNT_W(CNT_W_P)) u_cap (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .pin_i (cap_i[j]),
            .rise_i(st_q.ctrl[C_EDGE+j]),
            .cnt_i (cnt_w),
            .val_o (cap_val_o[j]),
            .evt_o (cap_evt[j])
        );
    end

    // flag sources and software clear
    always_comb begin
        set_vec        = '0;
        set_vec[0]     = ovf_w;
        set_vec[F_CAP +: NCAP_P] = cap_evt;
        for (int i = 0; i < NCMP_P; i++) begin
            if (tick_w && nxt_w == st_q.cmp_act[i]) set_vec[F_OC+i] = 1'b1;
        end
        clr_mask = (wr_en_i && wr_addr_i == ADDR_W_P'(A_FCLR)) ? wr_data_i[NFLAG-1:0] : '0;
        keep_w   = st_q.flags & ~clr_mask;
    end

    // register file, shadow transfer, pair gate
    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            if (wr_addr_i == '0) st_d.reload = wr_data_i;
            for (int i = 0; i < NCMP_P; i++) begin
                if (wr_addr_i == ADDR_W_P'(A_CMP0 + i)) st_d.cmp_sh[i] = wr_data_i;
            end
            if (wr_addr_i == ADDR_W_P'(A_PSC))  st_d.psc  = wr_data_i[PSC_W_P-1:0];
            if (wr_addr_i == ADDR_W_P'(A_CTRL)) st_d.ctrl = wr_data_i[CTRL_W-1:0];
            if (wr_addr_i == ADDR_W_P'(A_IEN))  st_d.ien  = wr_data_i[NFLAG-1:0];
        end
        if (ovf_w) begin
            st_d.cmp_act = st_q.cmp_sh;
            st_d.gate    = ~st_q.gate;
        end
        st_d.flags = keep_w | set_vec;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign alt_on = st_q.ctrl[C_ALT] && st_q.ctrl[C_PWM] && !st_q.ctrl[C_SYM];

    for (genvar i = 0; i < NCMP_P; i++) begin : g_out
        localparam bit EVEN = ((i % 2) == 0);
        logic en_ch;
        assign en_ch   = !alt_on || (st_q.gate == EVEN);
        assign act[i]  = st_q.ctrl[C_PWM] && en_ch && (cnt_w < st_q.cmp_act[i]);
        assign pwm_o[i] = act[i] ^ st_q.ctrl[C_POL+i];
    end

    assign flags_o = st_q.flags;
    assign irq_o   = |(st_q.flags & st_q.ien);

    // R7: the two channels of a pair are never active together
    for (genvar p = 0; p + 1 < NCMP_P; p += 2) begin : g_pair_chk
        p_alt_pair_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            alt_on |-> !(act[p] && act[p+1]));
    end

    // R8: active compares change only at an overflow point
    p_shadow_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ovf_w |=> $stable(st_q.cmp_act));

    // R9: with PWM off every output sits at its polarity level
    p_off_level_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.ctrl[C_PWM] |-> (pwm_o == st_q.ctrl[C_POL +: NCMP_P]));

    // R11: a set flag survives unless software clears it
    p_flag_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((st_q.flags & $past(keep_w)) == $past(keep_w)));
endmodule

// File: tb/ccpwm_top_tb.sv
module ccpwm_top_tb;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [3:0]  wr_addr_i = '0;
    logic [15:0] wr_data_i = '0;
    logic [1:0]  cap_i = '0;
    logic [3:0]  pwm_o;
    logic [1:0][15:0] cap_val_o;
    logic [6:0]  flags_o;
    logic        irq_o;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk_i = ~clk_i;

    ccpwm_top u_dut (
        .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .cap_i(cap_i), .pwm_o(pwm_o), .cap_val_o(cap_val_o),
        .flags_o(flags_o), .irq_o(irq_o)
    );

    typedef struct packed {
        logic [15:0]      ctrl;
        logic [15:0]      rel;
        logic [15:0]      psc;
        logic [3:0][15:0] cmp;   // listed D, C, B, A
        logic [15:0]      win;
        logic [3:0][15:0] exp;   // high samples per window, D, C, B, A
    } vec_t;

    localparam vec_t VECS [6] = '{
        // R1 R3: edge-aligned, zero and over-reload compares
        '{ctrl:16'h003, rel:16'd9, psc:16'd0, cmp:{16'd12,16'd10,16'd0,16'd4},
          win:16'd20, exp:{16'd20,16'd20,16'd0,16'd8}},
        // R2 R4: divide by 3, A and C inverted
        '{ctrl:16'h0A3, rel:16'd7, psc:16'd2, cmp:{16'd0,16'd3,16'd5,16'd1},
          win:16'd48, exp:{16'd0,16'd30,16'd30,16'd42}},
        // R6: center-aligned
        '{ctrl:16'h007, rel:16'd6, psc:16'd0, cmp:{16'd0,16'd7,16'd3,16'd1},
          win:16'd24, exp:{16'd0,16'd24,16'd10,16'd2}},
        // R7: alternating pairs
        '{ctrl:16'h013, rel:16'd4, psc:16'd0, cmp:{16'd1,16'd5,16'd3,16'd2},
          win:16'd10, exp:{16'd1,16'd5,16'd3,16'd2}},
        // R9: PWM off, B and D at inverted level
        '{ctrl:16'h149, rel:16'd5, psc:16'd0, cmp:{16'd1,16'd1,16'd1,16'd1},
          win:16'd12, exp:{16'd12,16'd0,16'd12,16'd0}},
        // R5: direction bit set in edge-aligned mode
        '{ctrl:16'h00B, rel:16'd9, psc:16'd0, cmp:{16'd0,16'd9,16'd1,16'd4},
          win:16'd20, exp:{16'd0,16'd18,16'd2,16'd8}}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the following negedge
    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk_i);
        wr_en_i = 1'b0;
    endtask

    task automatic do_reset();
        rst_ni = 1'b0; wr_en_i = 1'b0; cap_i = '0;
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
    endtask

    task automatic wait_ovf();
        while (!flags_o[0]) @(negedge clk_i);
    endtask

    task automatic period(input string req, input int exp);
        int n;
        wr(4'd8, 16'h0001);
        wait_ovf();
        wr(4'd8, 16'h0001);
        n = 1;
        while (!flags_o[0]) begin @(negedge clk_i); n++; end
        chk(req, n, exp);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk_i);
        do_reset();
        // reset state
        chk("R9 reset outputs", int'(pwm_o), 0);
        chk("R11 reset flags", int'(flags_o), 0);
        chk("R12 reset irq", int'(irq_o), 0);
        chk("R10 reset capture", int'(cap_val_o), 0);

        // vector table
        foreach (VECS[v]) begin
            int hc [4];
            do_reset();
            wr(4'd0, VECS[v].rel);
            for (int i = 0; i < 4; i++) wr(4'(i + 1), VECS[v].cmp[i]);
            wr(4'd5, VECS[v].psc);
            wr(4'd6, VECS[v].ctrl);
            repeat (2 * int'(VECS[v].win) + 8) @(negedge clk_i);
            for (int i = 0; i < 4; i++) hc[i] = 0;
            for (int k = 0; k < int'(VECS[v].win); k++) begin
                for (int i = 0; i < 4; i++) hc[i] += int'(pwm_o[i]);
                @(negedge clk_i);
            end
            for (int i = 0; i < 4; i++)
                chk($sformatf("R3 vector %0d channel %0d", v, i), hc[i], int'(VECS[v].exp[i]));
        end

        // R1 R2 R6: overflow spacing
        do_reset();
        wr(4'd0, 16'd9); wr(4'd6, 16'h003);
        period("R1 period reload 9", 10);
        wr(4'd0, 16'd3); wr(4'd5, 16'd4);
        period("R2 period divide by 5", 20);
        wr(4'd0, 16'd0); wr(4'd5, 16'd1023);
        period("R2 period divide by 1024", 1024);
        do_reset();
        wr(4'd0, 16'd6); wr(4'd6, 16'h007);
        period("R6 center-aligned period", 12);

        // R8: compare written mid-cycle waits for the reload
        do_reset();
        wr(4'd0, 16'd9); wr(4'd1, 16'd4); wr(4'd6, 16'h003);
        wr(4'd8, 16'h0001);
        wait_ovf();
        wr(4'd1, 16'd10);
        begin
            int h = 0;
            for (int k = 0; k < 9; k++) begin h += int'(pwm_o[0]); @(negedge clk_i); end
            chk("R8 old compare until reload", h, 4);
            h = 0;
            for (int k = 0; k < 10; k++) begin h += int'(pwm_o[0]); @(negedge clk_i); end
            chk("R8 new compare after reload", h, 10);
        end
        chk("R11 compare A flag", int'(flags_o[3]), 1);

        // R10 R12: freeze the counter at 8, then capture
        wr(4'd8, 16'h0001);
        wait_ovf();
        wr(4'd6, 16'h202);
        wr(4'd7, 16'h0002);
        chk("R12 irq masked while overflow flag set", int'(irq_o), 0);
        cap_i[0] = 1'b1;
        repeat (4) @(negedge clk_i);
        chk("R10 capture A value", int'(cap_val_o[0]), 8);
        chk("R10 capture A flag", int'(flags_o[1]), 1);
        chk("R12 irq on enabled flag", int'(irq_o), 1);
        wr(4'd8, 16'h0002);
        chk("R11 flag cleared by write", int'(flags_o[1]), 0);
        chk("R12 irq after clear", int'(irq_o), 0);
        chk("R11 other flag kept", int'(flags_o[0]), 1);
        cap_i[1] = 1'b1;
        repeat (5) @(negedge clk_i);
        chk("R10 rising edge ignored on B value", int'(cap_val_o[1]), 0);
        chk("R10 rising edge ignored on B flag", int'(flags_o[2]), 0);
        cap_i[1] = 1'b0;
        repeat (5) @(negedge clk_i);
        chk("R10 falling capture B value", int'(cap_val_o[1]), 8);
        chk("R10 falling capture B flag", int'(flags_o[2]), 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule